// File: doc/BRIEF.md
# Variable-Page-Size Translation Lookaside Buffer with Access Rights

This block is a small fully associative address translation array. Each of its sixteen entries maps one page of an effective address space onto a 36-bit real address space, and each entry carries its own page size. The size can be any power of four from 4 KB to 4 GB. A lookup presents an address-space bit, an 8-bit process tag, a 32-bit effective address, an access kind (read, write or execute) and a privilege bit. One cycle later the block answers with a hit flag, the real address, the entry's four software attribute bits, a rights-violation flag and a flag that reports overlapping entries.

Entries are loaded through an indexed write port. The port takes one entry per cycle as a set of separate fields: match context, virtual page, real page, size code, six rights bits and attributes. The page size of an entry sets how many effective-address bits take part in its tag compare. The same size sets how many low bits pass straight through to the real address.

Top module: `vpt_tlb`

## Requirements
- R1: A synchronous active-high reset invalidates every entry. After reset every lookup misses until an entry is written. With no lookup request, all response outputs are zero.
- R2: When `wr_en` is high, the entry at `wr_idx` is replaced by the write fields on that clock edge. A lookup issued in the next cycle sees the new contents. A lookup issued in the same cycle as the write sees the old contents.
- R3: Size codes 1 to 11 give a page of 4 KB × 4^(code−1), with an offset of 10+2×code bits. Only the effective-address bits above the offset are compared with the entry's page number (`wr_epn` holds EA bits 31:12). An entry with size code 0 or 12 to 15 never matches.
- R4: An entry matches only if it is valid, its address-space bit equals `lk_as`, and its process tag equals `lk_pid`.
- R5: On a hit, the real address takes its offset bits from the effective address. Its remaining upper bits come from `{rpn, 12'b0}`, which is 36 bits wide.
- R6: The rights field is laid out as bit 0 user read, bit 1 user write, bit 2 user execute, bit 3 supervisor read, bit 4 supervisor write, bit 5 supervisor execute. `lk_super`=1 selects the supervisor triplet. `lk_acc` is coded 0 read, 1 write, 2 execute and 3 reserved.
- R7: A hit whose selected rights bit for the access is clear, or whose access code is 3, raises `rsp_fault`. Such a hit still reports `rsp_hit`, the real address and the attributes. A miss never raises `rsp_fault`.
- R8: When two or more entries match, `rsp_multi` is raised and the lowest-numbered matching entry supplies the result.
- R9: On a hit, `rsp_attr` returns the entry's four attribute bits. On a miss, `rsp_attr` and `rsp_ra` are zero.
- R10: A lookup request produces `rsp_valid`=1 with its result in the following cycle. A cycle without a request yields `rsp_valid`=0 and zero outputs in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one entry this cycle |
| wr_idx | input | 4 | Entry index to write |
| wr_valid | input | 1 | Valid bit of the written entry |
| wr_as | input | 1 | Address-space bit of the entry |
| wr_pid | input | 8 | Process tag of the entry |
| wr_epn | input | 20 | Effective page number (EA bits 31:12) |
| wr_rpn | input | 24 | Real page number (RA bits 35:12) |
| wr_size | input | 4 | Page size code |
| wr_perm | input | 6 | Rights bits, layout in R6 |
| wr_attr | input | 4 | Software attribute bits |
| lk_req | input | 1 | Lookup request |
| lk_as | input | 1 | Lookup address-space bit |
| lk_pid | input | 8 | Lookup process tag |
| lk_ea | input | 32 | Effective address |
| lk_acc | input | 2 | Access kind, code in R6 |
| lk_super | input | 1 | Supervisor privilege |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_fault | output | 1 | Rights violation on a hit |
| rsp_ra | output | 36 | Real address |
| rsp_attr | output | 4 | Attributes of the chosen entry |

## Verification
The hardest case to reach from the ports is two live entries of different sizes matching one address. A larger page must cover a smaller one while both share the same context. Random effective addresses across a 32-bit space almost never produce this. The stimulus therefore limits random process tags to four values and builds most lookup addresses from a stored entry's page number with random offset bits, which makes overlaps frequent. A directed pair of overlapping 16 KB and 4 KB pages then pins down the lowest-index priority.

// File: rtl/vpt_tlb_pkg.sv
package vpt_tlb_pkg;

    localparam int EA_W    = 32;
    localparam int RA_W    = 36;
    localparam int PID_W   = 8;
    localparam int MIN_OFF = 12;
    localparam int SZ_W    = 4;
    localparam int ATTR_W  = 4;
    localparam int EPN_W   = EA_W - MIN_OFF;
    localparam int RPN_W   = RA_W - MIN_OFF;
    localparam int SZ_MIN  = 1;
    localparam int SZ_MAX  = 11;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    // r in bit 0, w in bit 1, x in bit 2
    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } rights_t;

    // user triplet in bits 2:0, supervisor triplet in bits 5:3
    typedef struct packed {
        rights_t sup;
        rights_t usr;
    } perm_t;

    typedef struct packed {
        logic              valid;
        logic              as;
        logic [PID_W-1:0]  pid;
        logic [EPN_W-1:0]  epn;
        logic [RPN_W-1:0]  rpn;
        logic [SZ_W-1:0]   size;
        perm_t             perm;
        logic [ATTR_W-1:0] attr;
    } tlb_entry_t;

    function automatic logic size_legal(logic [SZ_W-1:0] sz);
        return (int'(sz) >= SZ_MIN) && (int'(sz) <= SZ_MAX);
    endfunction

    // offset width for a legal code: 10 + 2*code
    function automatic int off_bits(logic [SZ_W-1:0] sz);
        if (size_legal(sz))
            return 10 + 2 * int'(sz);
        return MIN_OFF;
    endfunction

    function automatic logic [EA_W-1:0] off_mask(logic [SZ_W-1:0] sz);
        logic [EA_W-1:0] m;
        int n;
        n = off_bits(sz);
        for (int i = 0; i < EA_W; i++)
            m[i] = (i < n);
        return m;
    endfunction

    // bits of the page number that take part in the compare
    function automatic logic [EPN_W-1:0] epn_mask(logic [SZ_W-1:0] sz);
        logic [EA_W-1:0] m;
        m = off_mask(sz);
        return ~m[EA_W-1:MIN_OFF];
    endfunction

    function automatic logic access_ok(perm_t p, logic sup, acc_e a);
        rights_t r;
        r = sup ? p.sup : p.usr;
        case (a)
            ACC_READ:  return r.r;
            ACC_WRITE: return r.w;
            ACC_EXEC:  return r.x;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/vpt_tlb_store.sv
module vpt_tlb_store
    import vpt_tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int IDX_W       = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  tlb_entry_t                   wr_data,
    output tlb_entry_t [NUM_ENTRIES-1:0] ent_o
);

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        tlb_entry_t ent_q;
        always_ff @(posedge clk) begin
            if (rst)
                ent_q <= '0;
            else if (wr_en && (32'(wr_idx) == g))
                ent_q <= wr_data;
        end
        assign ent_o[g] = ent_q;
    end

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (32'(wr_idx) < NUM_ENTRIES)) |=> (ent_o[$past(wr_idx)] == $past(wr_data)));

    assert_reset_clears_R1: assert property (@(posedge clk)
        $past(rst) |-> (ent_o[0].valid == 1'b0));

endmodule

// File: rtl/vpt_tlb_match.sv
module vpt_tlb_match
    import vpt_tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  tlb_entry_t [NUM_ENTRIES-1:0] ent_i,
    input  logic                         lk_as,
    input  logic [PID_W-1:0]             lk_pid,
    input  logic [EPN_W-1:0]             lk_page,
    output logic [NUM_ENTRIES-1:0]       match_o
);

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        logic             ctx_ok;
        logic             tag_ok;
        logic [EPN_W-1:0] diff;
        assign ctx_ok  = ent_i[g].valid && size_legal(ent_i[g].size)
                      && (ent_i[g].as == lk_as) && (ent_i[g].pid == lk_pid);
        assign diff    = (ent_i[g].epn ^ lk_page) & epn_mask(ent_i[g].size);
        assign tag_ok  = (diff == '0);
        assign match_o[g] = ctx_ok && tag_ok;
    end

endmodule

// File: rtl/vpt_tlb_pick.sv
module vpt_tlb_pick #(
    parameter int NUM_ENTRIES = 16,
    parameter int IDX_W       = 4
) (
    input  logic [NUM_ENTRIES-1:0] match_i,
    output logic                   hit_o,
    output logic                   multi_o,
    output logic [IDX_W-1:0]       sel_o
);

    always_comb begin
        sel_o = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (match_i[i])
                sel_o = IDX_W'(i);
        end
    end

    always_comb begin
        logic seen;
        seen    = 1'b0;
        multi_o = 1'b0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (match_i[i]) begin
                if (seen)
                    multi_o = 1'b1;
                seen = 1'b1;
            end
        end
        hit_o = seen;
    end

endmodule

// File: rtl/vpt_tlb_resp.sv
module vpt_tlb_resp
    import vpt_tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_req,
    input  logic              hit_i,
    input  logic              multi_i,
    input  logic [RPN_W-1:0]  sel_rpn,
    input  logic [SZ_W-1:0]   sel_size,
    input  perm_t             sel_perm,
    input  logic [ATTR_W-1:0] sel_attr,
    input  logic [EA_W-1:0]   lk_ea,
    input  acc_e              lk_acc,
    input  logic              lk_super,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_multi,
    output logic              rsp_fault,
    output logic [RA_W-1:0]   rsp_ra,
    output logic [ATTR_W-1:0] rsp_attr
);

    localparam int EXT_W = RA_W - EA_W;

    logic [EA_W-1:0] om;
    logic [RA_W-1:0] ra_c;
    logic            ok_c;

    assign om   = off_mask(sel_size);
    assign ra_c = ({sel_rpn, {MIN_OFF{1'b0}}} & ~{{EXT_W{1'b0}}, om})
                | {{EXT_W{1'b0}}, lk_ea & om};
    assign ok_c = access_ok(sel_perm, lk_super, lk_acc);

    always_ff @(posedge clk) begin
        if (rst || !lk_req) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_multi <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_ra    <= '0;
            rsp_attr  <= '0;
        end else begin
            rsp_valid <= 1'b1;
            rsp_hit   <= hit_i;
            rsp_multi <= multi_i;
            rsp_fault <= hit_i && !ok_c;
            rsp_ra    <= hit_i ? ra_c : '0;
            rsp_attr  <= hit_i ? sel_attr : '0;
        end
    end

    assert_fault_needs_hit_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> rsp_hit);

    assert_multi_needs_hit_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_multi |-> rsp_hit);

    assert_miss_is_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_ra == '0 && rsp_attr == '0));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> (!rsp_valid && !rsp_hit && !rsp_fault));

    assert_req_answered_R10: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> rsp_valid);

    assert_low_offset_R5: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> (!rsp_hit || rsp_ra[MIN_OFF-1:0] == $past(lk_ea[MIN_OFF-1:0])));

endmodule

// File: rtl/vpt_tlb.sv
module vpt_tlb
    import vpt_tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [3:0]  wr_idx,
    input  logic        wr_valid,
    input  logic        wr_as,
    input  logic [7:0]  wr_pid,
    input  logic [19:0] wr_epn,
    input  logic [23:0] wr_rpn,
    input  logic [3:0]  wr_size,
    input  logic [5:0]  wr_perm,
    input  logic [3:0]  wr_attr,
    input  logic        lk_req,
    input  logic        lk_as,
    input  logic [7:0]  lk_pid,
    input  logic [31:0] lk_ea,
    input  logic [1:0]  lk_acc,
    input  logic        lk_super,
    output logic        rsp_valid,
    output logic        rsp_hit,
    output logic        rsp_multi,
    output logic        rsp_fault,
    output logic [35:0] rsp_ra,
    output logic [3:0]  rsp_attr
);

    localparam int IDX_W = 4;

    tlb_entry_t                   wr_data;
    tlb_entry_t [NUM_ENTRIES-1:0] ents;
    logic [NUM_ENTRIES-1:0]       match;
    logic                         hit;
    logic                         multi;
    logic [IDX_W-1:0]             sel;

    always_comb begin
        wr_data       = '0;
        wr_data.valid = wr_valid;
        wr_data.as    = wr_as;
        wr_data.pid   = wr_pid;
        wr_data.epn   = wr_epn;
        wr_data.rpn   = wr_rpn;
        wr_data.size  = wr_size;
        wr_data.perm  = perm_t'(wr_perm);
        wr_data.attr  = wr_attr;
    end

    vpt_tlb_store #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) store_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .ent_o   (ents)
    );

    vpt_tlb_match #(.NUM_ENTRIES(NUM_ENTRIES)) match_i (
        .ent_i   (ents),
        .lk_as   (lk_as),
        .lk_pid  (lk_pid),
        .lk_page (lk_ea[EA_W-1:MIN_OFF]),
        .match_o (match)
    );

    vpt_tlb_pick #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) pick_i (
        .match_i (match),
        .hit_o   (hit),
        .multi_o (multi),
        .sel_o   (sel)
    );

    vpt_tlb_resp resp_i (
        .clk       (clk),
        .rst       (rst),
        .lk_req    (lk_req),
        .hit_i     (hit),
        .multi_i   (multi),
        .sel_rpn   (ents[sel].rpn),
        .sel_size  (ents[sel].size),
        .sel_perm  (ents[sel].perm),
        .sel_attr  (ents[sel].attr),
        .lk_ea     (lk_ea),
        .lk_acc    (acc_e'(lk_acc)),
        .lk_super  (lk_super),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_multi (rsp_multi),
        .rsp_fault (rsp_fault),
        .rsp_ra    (rsp_ra),
        .rsp_attr  (rsp_attr)
    );

    assert_multi_overlap_R8: assert property (@(posedge clk) disable iff (rst)
        (lk_req && $countones(match) > 1) |=> rsp_multi);

endmodule

// File: tb/vpt_tlb_tb.sv
module vpt_tlb_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, wr_valid, wr_as;
    logic [3:0]  wr_idx, wr_size, wr_attr;
    logic [7:0]  wr_pid;
    logic [19:0] wr_epn;
    logic [23:0] wr_rpn;
    logic [5:0]  wr_perm;
    logic        lk_req, lk_as, lk_super;
    logic [7:0]  lk_pid;
    logic [31:0] lk_ea;
    logic [1:0]  lk_acc;
    logic        rsp_valid, rsp_hit, rsp_multi, rsp_fault;
    logic [35:0] rsp_ra;
    logic [3:0]  rsp_attr;

    int n_checks = 0;
    int n_fails  = 0;
    bit wd_fired = 0;

    // bench model of the array
    bit          m_valid[16];
    bit          m_as[16];
    logic [7:0]  m_pid[16];
    logic [19:0] m_epn[16];
    logic [23:0] m_rpn[16];
    logic [3:0]  m_sz[16];
    logic [5:0]  m_perm[16];
    logic [3:0]  m_attr[16];

    bit          e_hit, e_multi, e_fault;
    logic [35:0] e_ra;
    logic [3:0]  e_attr;

    always #4 clk = ~clk;

    vpt_tlb dut_i (.*);

    task automatic chk(input string tg, input string fld, input string rq,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s [%s] %s: actual %0h expected %0h", rq, tg, fld, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 16; i++) m_valid[i] = 0;
    endtask

    // expected result from the requirements R3..R9
    task automatic model_lookup();
        int first = -1;
        int cnt = 0;
        for (int i = 0; i < 16; i++) begin
            if (m_valid[i] && m_sz[i] >= 1 && m_sz[i] <= 11 &&
                m_as[i] == lk_as && m_pid[i] == lk_pid) begin
                int off = 10 + 2 * int'(m_sz[i]);
                longint unsigned a = 64'(lk_ea);
                longint unsigned b = 64'({m_epn[i], 12'h000});
                if ((a >> off) == (b >> off)) begin
                    cnt++;
                    if (first < 0) first = i;
                end
            end
        end
        e_hit = (cnt > 0);
        e_multi = (cnt > 1);
        e_fault = 0;
        e_ra = '0;
        e_attr = '0;
        if (e_hit) begin
            int off = 10 + 2 * int'(m_sz[first]);
            longint unsigned om = (64'd1 << off) - 1;
            longint unsigned pr = 64'({m_rpn[first], 12'h000});
            int bitn = (lk_super ? 3 : 0) + int'(lk_acc);
            e_ra = 36'((pr & ~om) | (64'(lk_ea) & om));
            e_attr = m_attr[first];
            if (lk_acc == 2'd3) e_fault = 1;
            else e_fault = !m_perm[first][bitn];
        end
    endtask

    task automatic cycle(input string tg);
        bit req = lk_req;
        if (req) model_lookup();
        if (wr_en) begin
            m_valid[wr_idx] = wr_valid;
            m_as[wr_idx] = wr_as;
            m_pid[wr_idx] = wr_pid;
            m_epn[wr_idx] = wr_epn;
            m_rpn[wr_idx] = wr_rpn;
            m_sz[wr_idx] = wr_size;
            m_perm[wr_idx] = wr_perm;
            m_attr[wr_idx] = wr_attr;
        end
        @(negedge clk);
        wr_en = 0;
        lk_req = 0;
        if (req) begin
            chk(tg, "valid", "R10", 64'(rsp_valid), 64'd1);
            chk(tg, "hit", "R3", 64'(rsp_hit), 64'(e_hit));
            chk(tg, "multi", "R8", 64'(rsp_multi), 64'(e_multi));
            chk(tg, "fault", "R7", 64'(rsp_fault), 64'(e_fault));
            chk(tg, "ra", "R5", 64'(rsp_ra), 64'(e_ra));
            chk(tg, "attr", "R9", 64'(rsp_attr), 64'(e_attr));
        end else begin
            chk(tg, "idle", "R10", 64'({rsp_valid, rsp_hit, rsp_fault, rsp_multi, rsp_ra, rsp_attr}), 64'd0);
        end
    endtask

    task automatic put(input int idx, input bit v, input bit as, input logic [7:0] pid,
                       input logic [19:0] epn, input logic [23:0] rpn, input logic [3:0] sz,
                       input logic [5:0] perm, input logic [3:0] attr);
        wr_en = 1; wr_idx = 4'(idx); wr_valid = v; wr_as = as; wr_pid = pid;
        wr_epn = epn; wr_rpn = rpn; wr_size = sz; wr_perm = perm; wr_attr = attr;
    endtask

    task automatic ask(input bit as, input logic [7:0] pid, input logic [31:0] ea,
                       input logic [1:0] acc, input bit sup);
        lk_req = 1; lk_as = as; lk_pid = pid; lk_ea = ea; lk_acc = acc; lk_super = sup;
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        model_clear();
    endtask

    task automatic run_all();
        // R1: empty after reset, idle outputs zero
        do_reset();
        cycle("R1 idle after reset");
        ask(0, 8'h80, 32'h1234_5678, 2'd0, 0);
        cycle("R1 empty array misses");

        // R2: same-cycle lookup sees old contents, next cycle sees new
        put(0, 1, 0, 8'h80, 20'h12345, 24'hABCDE0, 4'd1, 6'h3F, 4'h5);
        ask(0, 8'h80, 32'h1234_5678, 2'd0, 0);
        cycle("R2 same cycle old contents");
        ask(0, 8'h80, 32'h1234_5678, 2'd0, 0);
        cycle("R2 next cycle new contents");

        // R3/R5: 4 GB page matches any EA, upper RA nibble from rpn
        put(1, 1, 0, 8'h81, 20'h00000, 24'hA00000, 4'd11, 6'h3F, 4'h3);
        cycle("R3 load 4GB");
        ask(0, 8'h81, 32'hDEAD_BEEF, 2'd1, 1);
        cycle("R3 4GB page any EA");
        if (rsp_ra !== 36'hADEADBEEF) chk("R5 4GB ra", "ra", "R5", 64'(rsp_ra), 64'hADEADBEEF);
        // R3: 1 MB page (code 5, 20 offset bits)
        put(2, 1, 0, 8'h82, 20'h54321, 24'h777777, 4'd5, 6'h3F, 4'h9);
        cycle("R3 load 1MB");
        ask(0, 8'h82, 32'h543F_FFFF, 2'd0, 0);
        cycle("R3 1MB inside");
        ask(0, 8'h82, 32'h553F_FFFF, 2'd0, 0);
        cycle("R3 1MB outside");

        // R3: illegal size codes never match
        put(3, 1, 0, 8'h83, 20'h12345, 24'h1, 4'd0, 6'h3F, 4'h1);
        cycle("R3 load size 0");
        put(4, 1, 0, 8'h84, 20'h12345, 24'h2, 4'd12, 6'h3F, 4'h1);
        cycle("R3 load size 12");
        ask(0, 8'h83, 32'h1234_5000, 2'd0, 0);
        cycle("R3 size 0 no match");
        ask(0, 8'h84, 32'h1234_5000, 2'd0, 0);
        cycle("R3 size 12 no match");

        // R4: context mismatch
        ask(1, 8'h80, 32'h1234_5678, 2'd0, 0);
        cycle("R4 AS mismatch");
        ask(0, 8'h85, 32'h1234_5678, 2'd0, 0);
        cycle("R4 PID mismatch");

        // R6/R7: rights triplets and reserved access
        put(5, 1, 0, 8'h86, 20'h0AB00, 24'h0CD000, 4'd2, 6'b000001, 4'hC);
        cycle("R6 load user-read");
        ask(0, 8'h86, 32'h0AB0_0123, 2'd0, 0); cycle("R6 user read allowed");
        ask(0, 8'h86, 32'h0AB0_0123, 2'd1, 0); cycle("R7 user write fault");
        ask(0, 8'h86, 32'h0AB0_0123, 2'd2, 0); cycle("R7 user exec fault");
        ask(0, 8'h86, 32'h0AB0_0123, 2'd0, 1); cycle("R6 supervisor read fault");
        ask(0, 8'h86, 32'h0AB0_0123, 2'd3, 0); cycle("R6 reserved access fault");
        put(6, 1, 1, 8'h87, 20'h0FF00, 24'h0EE000, 4'd1, 6'b100000, 4'h2);
        cycle("R6 load sup-exec");
        ask(1, 8'h87, 32'h0FF0_0FFF, 2'd2, 1); cycle("R6 supervisor exec allowed");
        ask(1, 8'h87, 32'h0FF0_0FFF, 2'd2, 0); cycle("R7 user exec fault sup-only");

        // R8: overlapping 16 KB and 4 KB pages, lower index wins
        put(7, 1, 0, 8'h88, 20'h11110, 24'h300000, 4'd2, 6'h3F, 4'h7);
        cycle("R8 load big");
        put(8, 1, 0, 8'h88, 20'h11111, 24'h400000, 4'd1, 6'h3F, 4'h8);
        cycle("R8 load small");
        ask(0, 8'h88, 32'h1111_1234, 2'd0, 0); cycle("R8 overlap low index wins");
        ask(0, 8'h88, 32'h1111_0234, 2'd0, 0); cycle("R8 single match");
        // R2: overwrite with invalid removes entry 7
        put(7, 0, 0, 8'h88, 20'h11110, 24'h300000, 4'd2, 6'h3F, 4'h7);
        cycle("R2 invalidate");
        ask(0, 8'h88, 32'h1111_1234, 2'd0, 0); cycle("R2 after invalidate");
        cycle("R10 idle");

        // random phase
        for (int it = 0; it < 4000; it++) begin
            if ($urandom_range(0, 3) == 0) begin
                logic [3:0] sz = ($urandom_range(0, 9) == 0) ?
                    (($urandom_range(0, 1) == 0) ? 4'd0 : 4'($urandom_range(12, 15))) :
                    4'($urandom_range(1, 11));
                put(int'($urandom_range(0, 15)), ($urandom_range(0, 7) != 0),
                    1'($urandom_range(0, 1)), 8'($urandom_range(0, 3)),
                    20'($urandom), 24'($urandom), sz, 6'($urandom), 4'($urandom));
            end
            if ($urandom_range(0, 4) != 0) begin
                int k = int'($urandom_range(0, 15));
                int off = (m_sz[k] >= 1 && m_sz[k] <= 11) ? 10 + 2 * int'(m_sz[k]) : 12;
                longint unsigned om = (64'd1 << off) - 1;
                logic [31:0] ea = 32'((64'({m_epn[k], 12'h000}) & ~om) | (64'($urandom) & om));
                bit as = m_as[k];
                logic [7:0] pid = m_pid[k];
                if ($urandom_range(0, 4) == 0) ea = ea ^ (32'd1 << $urandom_range(12, 31));
                if ($urandom_range(0, 9) == 0) as = ~as;
                if ($urandom_range(0, 9) == 0) pid = 8'($urandom_range(0, 3));
                ask(as, pid, ea, 2'($urandom), 1'($urandom));
            end
            cycle("random R3 R4 R5 R7 R8");
        end

        // R1: reset mid-run wipes entries
        put(9, 1, 0, 8'h90, 20'h22222, 24'h5, 4'd1, 6'h3F, 4'h1);
        cycle("R1 load before reset");
        do_reset();
        ask(0, 8'h90, 32'h2222_2000, 2'd0, 0);
        cycle("R1 miss after reset");
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst = 1; wr_en = 0; wr_idx = 0; wr_valid = 0; wr_as = 0; wr_pid = 0;
        wr_epn = 0; wr_rpn = 0; wr_size = 0; wr_perm = 0; wr_attr = 0;
        lk_req = 0; lk_as = 0; lk_pid = 0; lk_ea = 0; lk_acc = 0; lk_super = 0;
        model_clear();
        @(negedge clk);
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd_fired = 1;
            end
        join_any
        disable fork;
        if (wd_fired) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule